// File: doc/BRIEF.md
# Jack-Detect Output Enable Gating

This block sits between the host's normal driver enables and four output drivers plus a mid-rail reference driver. When jack detection is on, one of three general-purpose input pins is taken as the detect signal. The pin is brought into the clock domain through a two-flop synchroniser. Its level then picks one of two programmed output masks and one of two reference-enable bits.

Each normal output enable is ANDed with its bit of the chosen mask. The normal reference enable is ORed with the chosen reference bit. When detection is off, the mask acts as all ones and the reference bit acts as zero, so the host's enables pass straight through. Both final enables are registered.

Two control registers are written through a plain address/data write port. A combinational read port returns their contents.

Top module: `jd_gate`

## Requirements
- R1: While rst_ni is low, out_en_o and ref_en_o are 0 and both registers read back 0.
- R2: With detection off (config bit 0 = 0), out_en_o equals out_en_i and ref_en_o equals ref_en_i one clock later.
- R3: Config bits [2:1] select the detect pin: 0 selects gpio_i[0], 1 selects gpio_i[1] and 2 selects gpio_i[2].
- R4: A select value of 3 is reserved, and the detect level is then taken as 0.
- R5: With detection on, out_en_o is the AND of out_en_i and the mask for the detect level. Mask register bits [3:0] apply when the level is 0, and bits [7:4] apply when it is 1. A normal enable of 0 keeps its output off.
- R6: With detection on, ref_en_o is the OR of ref_en_i and the reference bit for the detect level: config bit 3 when the level is low, config bit 4 when it is high.
- R7: A change on the selected pin reaches the outputs on the third rising clock edge after it, and not before.
- R8: A register write takes effect at the edge on which it is written. The outputs reflect it one edge later.
- R9: The config register is at address 9 and reads back as {3'b0, bits[4:0]}. The mask register is at address 13. Writes to any other address are ignored, and reads of any other address return 0.
- R10: An asynchronous reset in mid-operation clears both registers and the outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| gpio_i | input | 3 | Asynchronous candidate detect pins |
| out_en_i | input | 4 | Normal output driver enables |
| ref_en_i | input | 1 | Normal reference driver enable |
| out_en_o | output | 4 | Final output driver enables, registered |
| ref_en_o | output | 1 | Final reference driver enable, registered |

## Verification
The assertions assume that the host's normal enables and the write port change only between clock edges. They also assume the detect pins may change at any time but are sampled only through the synchroniser. The stimulus drives every input just after a falling edge and holds it over at least one rising edge. It lets a pin change settle for several cycles before the steady-state checks. The latency checks then sample the outputs after each single edge to pin down the edge on which a change first appears.

// File: rtl/jd_pkg.sv
package jd_pkg;
  localparam int NUM_OUT   = 4;
  localparam int NUM_PIN   = 3;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd13;
  localparam int CFG_W     = 3 + SEL_W;  // enable, select, two reference bits

  typedef struct packed {
    logic             ref_hi;
    logic             ref_lo;
    logic [SEL_W-1:0] sel;
    logic             det_en;
  } cfg_t;
endpackage

// File: rtl/jd_regs.sv
module jd_regs
  import jd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output cfg_t                cfg_o,
  output logic [NUM_OUT-1:0]  mask_lo_o,
  output logic [NUM_OUT-1:0]  mask_hi_o
);
  cfg_t                   cfg_q;
  logic [2*NUM_OUT-1:0]   mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_CFG)  cfg_q  <= cfg_t'(wr_data_i[CFG_W-1:0]);
      if (wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[2*NUM_OUT-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_CFG)       rd_data_o[CFG_W-1:0]     = cfg_q;
    else if (rd_addr_i == ADDR_MASK) rd_data_o[2*NUM_OUT-1:0] = mask_q;
  end

  assign cfg_o     = cfg_q;
  assign mask_lo_o = mask_q[NUM_OUT-1:0];
  assign mask_hi_o = mask_q[2*NUM_OUT-1:NUM_OUT];

  assert_unmapped_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != ADDR_CFG && wr_addr_i != ADDR_MASK)
      |=> ($stable(cfg_q) && $stable(mask_q)));

  assert_write_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_MASK) |=> (mask_q == $past(wr_data_i[2*NUM_OUT-1:0])));
endmodule

// File: rtl/jd_sync.sv
module jd_sync
  import jd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PIN-1:0] pins_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               det_o
);
  logic [NUM_PIN-1:0] s1_q, s2_q;

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[i] <= 1'b0;
        s2_q[i] <= 1'b0;
      end else begin
        s1_q[i] <= pins_i[i];
        s2_q[i] <= s1_q[i];
      end
    end

    assert_sync_depth_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(s2_q[i]) |-> $past(pins_i[i], 2));
  end

  // select after sync so a select change is seen at once
  always_comb begin
    det_o = 1'b0;
    for (int i = 0; i < NUM_PIN; i++)
      if (sel_i == SEL_W'(i)) det_o = s2_q[i];
  end

  assert_rsvd_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == {SEL_W{1'b1}}) |-> !det_o);
endmodule

// File: rtl/jd_combine.sv
module jd_combine
  import jd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cfg_t               cfg_i,
  input  logic               det_i,
  input  logic [NUM_OUT-1:0] mask_lo_i,
  input  logic [NUM_OUT-1:0] mask_hi_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  input  logic               ref_en_i,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               ref_en_o
);
  logic [NUM_OUT-1:0] mask_eff;
  logic               ref_eff;
  logic               past_ok_q;

  always_comb begin
    if (cfg_i.det_en) begin
      mask_eff = det_i ? mask_hi_i : mask_lo_i;
      ref_eff  = det_i ? cfg_i.ref_hi : cfg_i.ref_lo;
    end else begin
      mask_eff = '1;
      ref_eff  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_en_o  <= '0;
      ref_en_o  <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      out_en_o  <= out_en_i & mask_eff;
      ref_en_o  <= ref_en_i | ref_eff;
      past_ok_q <= 1'b1;
    end
  end

  assert_out_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((out_en_o & ~$past(out_en_i)) == '0));

  assert_ref_or_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(ref_en_i)) |-> ref_en_o);

  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(cfg_i.det_en))
      |-> (out_en_o == $past(out_en_i) && ref_en_o == $past(ref_en_i)));
endmodule

// File: rtl/jd_gate.sv
module jd_gate
  import jd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [NUM_PIN-1:0] gpio_i,
  input  logic [NUM_OUT-1:0] out_en_i,
  input  logic               ref_en_i,
  output logic [NUM_OUT-1:0] out_en_o,
  output logic               ref_en_o
);
  cfg_t               cfg;
  logic [NUM_OUT-1:0] mask_lo, mask_hi;
  logic               det;

  jd_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .cfg_o(cfg), .mask_lo_o(mask_lo), .mask_hi_o(mask_hi)
  );

  jd_sync u_sync (
    .clk_i, .rst_ni, .pins_i(gpio_i), .sel_i(cfg.sel), .det_o(det)
  );

  jd_combine u_combine (
    .clk_i, .rst_ni, .cfg_i(cfg), .det_i(det),
    .mask_lo_i(mask_lo), .mask_hi_i(mask_hi),
    .out_en_i, .ref_en_i, .out_en_o, .ref_en_o
  );

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (out_en_o == '0 && !ref_en_o));
endmodule

// File: tb/jd_gate_tb.sv
`timescale 1ns/1ps
module jd_gate_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] gpio = '0;
  logic [3:0] out_en = '0;
  logic       ref_en = 1'b0;
  logic [3:0] out_en_o;
  logic       ref_en_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the registers
  logic       m_en = 0, m_rlo = 0, m_rhi = 0;
  logic [1:0] m_sel = 0;
  logic [3:0] m_lo = 0, m_hi = 0;

  string      q_tag[$];
  logic [12:0] q_exp[$];  // {rd[7:0], ref, out[3:0]}

  always #10 clk = ~clk;

  jd_gate u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .gpio_i(gpio), .out_en_i(out_en), .ref_en_i(ref_en),
    .out_en_o(out_en_o), .ref_en_o(ref_en_o)
  );

  function automatic logic [4:0] model_out();
    logic det;
    logic [3:0] mask;
    logic rb;
    det  = m_en && (m_sel != 2'd3) && gpio[m_sel];
    mask = m_en ? (det ? m_hi : m_lo) : 4'hF;
    rb   = m_en ? (det ? m_rhi : m_rlo) : 1'b0;
    return {ref_en | rb, out_en & mask};
  endfunction

  function automatic logic [7:0] model_rd();
    if (rd_addr == 4'd9)  return {3'b0, m_rhi, m_rlo, m_sel, m_en};
    if (rd_addr == 4'd13) return {m_hi, m_lo};
    return 8'h00;
  endfunction

  task automatic push(string tag, logic [4:0] o);
    q_tag.push_back(tag);
    q_exp.push_back({model_rd(), o});
  endtask

  // settle, queue expectation, wait for monitor
  task automatic check(string tag);
    repeat (4) @(posedge clk);
    #1 push(tag, model_out());
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 0;
    if (a == 4'd9) begin
      m_en = d[0]; m_sel = d[2:1]; m_rlo = d[3]; m_rhi = d[4];
    end else if (a == 4'd13) begin
      m_lo = d[3:0]; m_hi = d[7:4];
    end
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      string t;
      logic [12:0] e, a;
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      a = {rd_data, ref_en_o, out_en_o};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual rd=%h ref=%b out=%h expected rd=%h ref=%b out=%h",
                 t, a[12:5], a[4], a[3:0], e[12:5], e[4], e[3:0]);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] old;
    out_en = 4'hA; ref_en = 1'b1; rd_addr = 4'd9;
    repeat (3) @(posedge clk);
    #1 push("R1 reset state", 5'b0_0000);
    @(negedge clk); #1;
    rst_ni = 1;
    check("R2 pass-through after reset");
    rd_addr = 4'd13; check("R1 mask reads 0 after reset");

    wr(4'd13, 8'h5C);
    wr(4'd9, 8'h01);
    out_en = 4'hF; ref_en = 0; gpio = 3'b000;
    check("R5 low mask applied");
    gpio = 3'b001; check("R5 R3 high mask pin0");
    wr(4'd9, 8'h03); gpio = 3'b000; check("R3 select pin1 low");
    gpio = 3'b010; check("R3 select pin1 high");
    gpio = 3'b101; check("R3 pin1 low others high");
    wr(4'd9, 8'h05); gpio = 3'b100; check("R3 select pin2 high");
    wr(4'd9, 8'h07); gpio = 3'b111; check("R4 reserved select reads low");

    wr(4'd9, 8'h09); gpio = 3'b000; ref_en = 0; check("R6 low ref bit");
    gpio = 3'b001; check("R6 high ref bit clear");
    ref_en = 1; check("R6 normal ref passes");
    out_en = 4'h3; check("R5 normal off stays off");

    rd_addr = 4'd9; wr(4'd9, 8'hFF); check("R9 config readback masks unused");
    wr(4'd5, 8'hFF); check("R9 unmapped write ignored cfg");
    rd_addr = 4'd13; check("R9 unmapped write ignored mask");
    rd_addr = 4'd5; check("R9 unmapped read zero");

    // R8 latency
    wr(4'd9, 8'h01); gpio = 3'b000; out_en = 4'hF; ref_en = 0; rd_addr = 4'd13;
    check("R8 setup");
    old = model_out();
    wr(4'd13, 8'h00);
    push("R8 old value before output edge", old);
    @(posedge clk); #1 push("R8 new value one edge later", model_out());
    @(negedge clk); #1;

    // R7 synchroniser latency
    wr(4'd13, 8'hF0); check("R7 setup");
    old = model_out();
    gpio = 3'b001;
    @(posedge clk); #1 push("R7 no change after edge 1", old);
    @(posedge clk); #1 push("R7 no change after edge 2", old);
    @(posedge clk); #1 push("R7 change after edge 3", model_out());
    @(negedge clk); #1;

    rd_addr = 4'd9; wr(4'd9, 8'h00); out_en = 4'h6; ref_en = 1;
    check("R2 detection off pass-through");

    // R10 async reset mid-run
    wr(4'd9, 8'h19); wr(4'd13, 8'h33);
    ref_en = 0; out_en = 4'hF;
    check("R10 pre-reset config");
    #4 rst_ni = 0;
    m_en = 0; m_sel = 0; m_rlo = 0; m_rhi = 0; m_lo = 0; m_hi = 0;
    #2 push("R10 async clear", 5'b0_0000);
    @(negedge clk); #1;
    rd_addr = 4'd13; #1 push("R10 mask cleared", 5'b0_0000);
    @(negedge clk); #1;
    rst_ni = 1;
    check("R10 pass-through after reset");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule